// File: doc/BRIEF.md
# Share Remask and Compression Stage

This block sits between two rounds of a first-order masked datapath. A round whose nonlinear layer skipped share compression leaves every state bit spread over four shares, one per pair of domain indices (i, j). The stage adds fresh randomness to each of those four shares and stores the refreshed shares in a register bank. After the bank it folds them back into two output shares per bit. Because every bit is reshared, no share leaving the stage depends on a share that entered it in the previous round without a fresh mask between them.

For the low-order bits that the next round must see twice, a second lane runs the same remask, register and fold path on the same expanded shares. It uses its own random input, so it yields a second two-share encoding of the same values that is unrelated to the first one. Random generation and round sequencing sit outside the block. The block takes random words and a load strobe each round.

Top module: `share_refresh_stage`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stored share clears, so all four output buses read zero after that edge.
- R2: When `load_en` is high at an edge (and `rst` low), after that edge `main_sh0 ^ main_sh1` equals the XOR of the four input shares for every bit.
- R3: When `load_en` is low at an edge (and `rst` low), all output buses keep their values, whatever the data and random inputs do.
- R4: Input share k (k = 2i + j, held in bits `[k*N_BITS +: N_BITS]` of `exp_shares`) is remasked with `r[k] ^ r[(k+1) mod 4]`, where `r[k]` is bits `[k*N_BITS +: N_BITS]` of `rand_main`. Random words placed only in shares 1 and 3 therefore leave both outputs unmasked.
- R5: The fold happens after the register. `main_sh0` is refreshed share 0 XOR refreshed share 1, and `main_sh1` is refreshed share 2 XOR refreshed share 3. Taken together with R4, `main_sh0 = s0^s1^r0^r2` and `main_sh1 = s2^s3^r2^r0`.
- R6: The duplicate lane covers the low `N_DUP` bits of every share and draws its random words from `rand_dup`, with share k in bits `[k*N_DUP +: N_DUP]`. Its outputs are `dup_sh0 = s0^s1^b0^b2` and `dup_sh1 = s2^s3^b2^b0`, and `dup_sh0 ^ dup_sh1` equals the low `N_DUP` bits of `main_sh0 ^ main_sh1`.
- R7: The two lanes use separate randomness. Changing only `rand_dup` leaves the main outputs unchanged, and changing only `rand_main` leaves the duplicate outputs unchanged.
- R8: Reset takes priority over `load_en`. With both high, the outputs read zero after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Captures the refreshed shares at the next edge |
| exp_shares | input | 4*N_BITS | Expanded sharing; share k = 2i+j in bits [k*N_BITS +: N_BITS] |
| rand_main | input | 4*N_BITS | One fresh bit per share per bit for the main lane |
| rand_dup | input | 4*N_DUP | One fresh bit per share per bit for the duplicate lane |
| main_sh0 | output | N_BITS | Main lane output share, domain 0 |
| main_sh1 | output | N_BITS | Main lane output share, domain 1 |
| dup_sh0 | output | N_DUP | Duplicate lane output share, domain 0 |
| dup_sh1 | output | N_DUP | Duplicate lane output share, domain 1 |

## Verification
The assertions check the following on every cycle:
- a load preserves the recombined value in both lanes;
- each lane's output shares equal the fold of the captured inputs with that lane's own random words;
- the outputs stay put whenever no load occurs.

Only the bench's scenarios can show two other behaviours. The first is the clearing effect of reset, including reset winning over a simultaneous load. The second is that random words on shares 1 and 3 cancel completely, and that varying one lane's random input leaves the other lane's output unchanged.

// File: rtl/share_refresh_pkg.sv
package share_refresh_pkg;

  // First-order sharing: d = 1
  localparam int ORDER      = 1;
  localparam int DOMAINS    = ORDER + 1;          // output shares per bit
  localparam int EXP_SHARES = DOMAINS * DOMAINS;  // expanded shares per bit

  // Mask applied to expanded share k, built from the bit's random vector.
  // Neighbouring shares reuse one random bit, so the pattern cancels overall.
  function automatic logic cyc_mask(input logic [EXP_SHARES-1:0] rbits, input int k);
    return rbits[k] ^ rbits[(k + 1) % EXP_SHARES];
  endfunction

  // Output domain that expanded share k (k = i*DOMAINS + j) folds into.
  function automatic int fold_domain(input int k);
    return k / DOMAINS;
  endfunction

endpackage

// File: rtl/shr_remask.sv
module shr_remask
  import share_refresh_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [EXP_SHARES*W-1:0] shares_in,
  input  logic [EXP_SHARES*W-1:0] rnd,
  output logic [EXP_SHARES*W-1:0] shares_out
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [EXP_SHARES-1:0] rbits;
    for (genvar k = 0; k < EXP_SHARES; k++) begin : g_gather
      assign rbits[k] = rnd[k*W + b];
    end
    for (genvar k = 0; k < EXP_SHARES; k++) begin : g_share
      assign shares_out[k*W + b] = shares_in[k*W + b] ^ cyc_mask(rbits, k);
    end
  end

endmodule

// File: rtl/shr_bank.sv
module shr_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/shr_fold.sv
module shr_fold
  import share_refresh_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [EXP_SHARES*W-1:0] stored,
  output logic [DOMAINS*W-1:0]    folded
);

  for (genvar d = 0; d < DOMAINS; d++) begin : g_dom
    always_comb begin
      folded[d*W +: W] = '0;
      for (int k = 0; k < EXP_SHARES; k++) begin
        if (fold_domain(k) == d) folded[d*W +: W] = folded[d*W +: W] ^ stored[k*W +: W];
      end
    end
  end

endmodule

// File: rtl/shr_lane.sv
module shr_lane
  import share_refresh_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [EXP_SHARES*W-1:0] shares_in,
  input  logic [EXP_SHARES*W-1:0] rnd,
  output logic [DOMAINS*W-1:0]    folded
);

  logic [EXP_SHARES*W-1:0] fresh;
  logic [EXP_SHARES*W-1:0] stored;

  shr_remask #(.W(W)) i_remask (
    .shares_in (shares_in),
    .rnd       (rnd),
    .shares_out(fresh)
  );

  shr_bank #(.W(EXP_SHARES*W)) i_bank (
    .clk(clk),
    .rst(rst),
    .en (load),
    .d  (fresh),
    .q  (stored)
  );

  shr_fold #(.W(W)) i_fold (
    .stored(stored),
    .folded(folded)
  );

endmodule

// File: rtl/share_refresh_stage.sv
module share_refresh_stage
  import share_refresh_pkg::*;
#(
  parameter int N_BITS = 8,
  parameter int N_DUP  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_en,
  input  logic [EXP_SHARES*N_BITS-1:0] exp_shares,
  input  logic [EXP_SHARES*N_BITS-1:0] rand_main,
  input  logic [EXP_SHARES*N_DUP-1:0]  rand_dup,
  output logic [N_BITS-1:0]            main_sh0,
  output logic [N_BITS-1:0]            main_sh1,
  output logic [N_DUP-1:0]             dup_sh0,
  output logic [N_DUP-1:0]             dup_sh1
);

  // Named internal events for the checker and for readability
  logic                         capture;
  logic [EXP_SHARES*N_DUP-1:0]  dup_src;
  logic [DOMAINS*N_BITS-1:0]    main_fold;
  logic [DOMAINS*N_DUP-1:0]     dup_fold;

  assign capture = load_en & ~rst;

  // Low N_DUP bits of every expanded share feed the duplicate lane
  for (genvar k = 0; k < EXP_SHARES; k++) begin : g_dup_src
    assign dup_src[k*N_DUP +: N_DUP] = exp_shares[k*N_BITS +: N_DUP];
  end

  shr_lane #(.W(N_BITS)) i_main_lane (
    .clk      (clk),
    .rst      (rst),
    .load     (load_en),
    .shares_in(exp_shares),
    .rnd      (rand_main),
    .folded   (main_fold)
  );

  shr_lane #(.W(N_DUP)) i_dup_lane (
    .clk      (clk),
    .rst      (rst),
    .load     (load_en),
    .shares_in(dup_src),
    .rnd      (rand_dup),
    .folded   (dup_fold)
  );

  assign main_sh0 = main_fold[0 +: N_BITS];
  assign main_sh1 = main_fold[N_BITS +: N_BITS];
  assign dup_sh0  = dup_fold[0 +: N_DUP];
  assign dup_sh1  = dup_fold[N_DUP +: N_DUP];

endmodule

// File: rtl/share_refresh_stage_chk.sv
module share_refresh_stage_chk #(
  parameter int N_BITS = 8,
  parameter int N_DUP  = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                load_en,
  input logic                capture,
  input logic [4*N_BITS-1:0] exp_shares,
  input logic [4*N_BITS-1:0] rand_main,
  input logic [4*N_DUP-1:0]  rand_dup,
  input logic [N_BITS-1:0]   main_sh0,
  input logic [N_BITS-1:0]   main_sh1,
  input logic [N_DUP-1:0]    dup_sh0,
  input logic [N_DUP-1:0]    dup_sh1
);

  logic [N_BITS-1:0] s0, s1, s2, s3, in_sum, main_lo_pred;
  logic [N_DUP-1:0]  dup_lo_pred;

  assign s0 = exp_shares[0*N_BITS +: N_BITS];
  assign s1 = exp_shares[1*N_BITS +: N_BITS];
  assign s2 = exp_shares[2*N_BITS +: N_BITS];
  assign s3 = exp_shares[3*N_BITS +: N_BITS];
  assign in_sum = s0 ^ s1 ^ s2 ^ s3;
  assign main_lo_pred = s0 ^ s1 ^ rand_main[0 +: N_BITS] ^ rand_main[2*N_BITS +: N_BITS];
  assign dup_lo_pred  = s0[N_DUP-1:0] ^ s1[N_DUP-1:0]
                      ^ rand_dup[0 +: N_DUP] ^ rand_dup[2*N_DUP +: N_DUP];

  // R2
  recombine_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> ((main_sh0 ^ main_sh1) == $past(in_sum)));

  // R6
  dup_value_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> ((dup_sh0 ^ dup_sh1) == $past(in_sum[N_DUP-1:0])));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ($stable(main_sh0) && $stable(main_sh1) && $stable(dup_sh0) && $stable(dup_sh1)));

  // R5
  fold_map_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> (main_sh0 == $past(main_lo_pred)));

  // R7
  dup_rand_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> (dup_sh0 == $past(dup_lo_pred)));

endmodule

bind share_refresh_stage share_refresh_stage_chk #(.N_BITS(N_BITS), .N_DUP(N_DUP)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .load_en   (load_en),
  .capture   (capture),
  .exp_shares(exp_shares),
  .rand_main (rand_main),
  .rand_dup  (rand_dup),
  .main_sh0  (main_sh0),
  .main_sh1  (main_sh1),
  .dup_sh0   (dup_sh0),
  .dup_sh1   (dup_sh1)
);

// File: tb/test_share_refresh_stage.sv
module test_share_refresh_stage;

  localparam int N  = 8;
  localparam int ND = 3;
  localparam int NV = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            load_en = 1'b0;
  logic [4*N-1:0]  exp_shares = '0;
  logic [4*N-1:0]  rand_main = '0;
  logic [4*ND-1:0] rand_dup = '0;
  logic [N-1:0]    main_sh0, main_sh1;
  logic [ND-1:0]   dup_sh0, dup_sh1;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  share_refresh_stage #(.N_BITS(N), .N_DUP(ND)) i_share_refresh_stage (
    .clk(clk), .rst(rst), .load_en(load_en), .exp_shares(exp_shares),
    .rand_main(rand_main), .rand_dup(rand_dup),
    .main_sh0(main_sh0), .main_sh1(main_sh1), .dup_sh0(dup_sh0), .dup_sh1(dup_sh1)
  );

  // {exp_shares, rand_main, rand_dup}
  localparam logic [8*N+4*ND-1:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 12'h000},
    {32'hFF00_FF00, 32'h0000_0000, 12'h000},
    {32'h1234_5678, 32'hA5A5_A5A5, 12'h5A5},
    {32'hDEAD_BEEF, 32'h0F0F_F0F0, 12'hFFF},
    {32'h8001_4002, 32'h7E7E_8181, 12'h3C3},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 12'h924}
  };

  function automatic logic [N-1:0] sh(input logic [4*N-1:0] v, input int k);
    return v[k*N +: N];
  endfunction
  function automatic logic [ND-1:0] shd(input logic [4*ND-1:0] v, input int k);
    return v[k*ND +: ND];
  endfunction

  // Expected outputs from the requirement formulas (R5, R6)
  function automatic logic [N-1:0] want_m0(input logic [4*N-1:0] s, input logic [4*N-1:0] r);
    return sh(s,0) ^ sh(s,1) ^ sh(r,0) ^ sh(r,2);
  endfunction
  function automatic logic [N-1:0] want_m1(input logic [4*N-1:0] s, input logic [4*N-1:0] r);
    return sh(s,2) ^ sh(s,3) ^ sh(r,2) ^ sh(r,0);
  endfunction
  function automatic logic [ND-1:0] want_d0(input logic [4*N-1:0] s, input logic [4*ND-1:0] b);
    logic [N-1:0] x;
    x = sh(s,0) ^ sh(s,1);
    return x[ND-1:0] ^ shd(b,0) ^ shd(b,2);
  endfunction
  function automatic logic [ND-1:0] want_d1(input logic [4*N-1:0] s, input logic [4*ND-1:0] b);
    logic [N-1:0] x;
    x = sh(s,2) ^ sh(s,3);
    return x[ND-1:0] ^ shd(b,2) ^ shd(b,0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a load at a falling edge; outputs are sampled one falling edge later
  task automatic do_load(input logic [4*N-1:0] s, input logic [4*N-1:0] r, input logic [4*ND-1:0] b);
    @(negedge clk);
    exp_shares = s; rand_main = r; rand_dup = b; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic check_all(input string tag, input logic [4*N-1:0] s, input logic [4*N-1:0] r,
                           input logic [4*ND-1:0] b);
    chk({tag, " R5 main_sh0"}, 32'(main_sh0), 32'(want_m0(s, r)));
    chk({tag, " R5 main_sh1"}, 32'(main_sh1), 32'(want_m1(s, r)));
    chk({tag, " R2 recombine"}, 32'(main_sh0 ^ main_sh1), 32'(sh(s,0)^sh(s,1)^sh(s,2)^sh(s,3)));
    chk({tag, " R6 dup_sh0"}, 32'(dup_sh0), 32'(want_d0(s, b)));
    chk({tag, " R6 dup_sh1"}, 32'(dup_sh1), 32'(want_d1(s, b)));
  endtask

  initial begin
    logic [4*N-1:0]  s, r;
    logic [4*ND-1:0] b;
    logic [N-1:0]    h0, h1;
    logic [ND-1:0]   hd0, hd1;

    // R1 / R8: reset with load_en also high and busy inputs
    exp_shares = 32'hCAFE_F00D; rand_main = 32'h1357_9BDF; rand_dup = 12'hABC; load_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 main_sh0 after reset", 32'(main_sh0), 32'h0);
    chk("R1 main_sh1 after reset", 32'(main_sh1), 32'h0);
    chk("R8 dup shares with load during reset", 32'({dup_sh0, dup_sh1}), 32'h0);
    rst = 1'b0; load_en = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      {s, r, b} = VEC[i];
      do_load(s, r, b);
      check_all($sformatf("vec%0d", i), s, r, b);
    end

    // R4: random words only on shares 1 and 3 cancel fully
    s = 32'h3C5A_96E1;
    r = {8'hFF, 8'h00, 8'h77, 8'h00};
    b = {3'b111, 3'b000, 3'b101, 3'b000};
    do_load(s, r, b);
    chk("R4 main_sh0 unmasked", 32'(main_sh0), 32'(sh(s,0) ^ sh(s,1)));
    chk("R4 main_sh1 unmasked", 32'(main_sh1), 32'(sh(s,2) ^ sh(s,3)));
    chk("R4 dup_sh0 unmasked", 32'(dup_sh0), 32'((sh(s,0) ^ sh(s,1)) & 8'h07));

    // R3: no load, inputs change, outputs hold
    h0 = main_sh0; h1 = main_sh1; hd0 = dup_sh0; hd1 = dup_sh1;
    @(negedge clk);
    exp_shares = ~exp_shares; rand_main = 32'h5555_AAAA; rand_dup = 12'h777;
    repeat (2) @(negedge clk);
    chk("R3 main hold", 32'({main_sh1, main_sh0}), 32'({h1, h0}));
    chk("R3 dup hold", 32'({dup_sh1, dup_sh0}), 32'({hd1, hd0}));

    // R7: change only rand_dup, then only rand_main
    s = 32'h0BAD_F00D; r = 32'h1111_2222; b = 12'h0F0;
    do_load(s, r, b);
    h0 = main_sh0; hd0 = dup_sh0;
    do_load(s, r, 12'hF0F);
    chk("R7 main unchanged by rand_dup", 32'(main_sh0), 32'(h0));
    chk("R7 dup follows rand_dup", 32'(dup_sh0), 32'(want_d0(s, 12'hF0F)));
    do_load(s, 32'h9999_4444, 12'hF0F);
    chk("R7 dup unchanged by rand_main", 32'(dup_sh0), 32'(want_d0(s, 12'hF0F)));
    chk("R7 main follows rand_main", 32'(main_sh0), 32'(want_m0(s, 32'h9999_4444)));

    // Random data and masks: R2 / R6 recombination
    for (int i = 0; i < 40; i++) begin
      s = $urandom; r = $urandom; b = 12'($urandom);
      do_load(s, r, b);
      check_all($sformatf("rnd%0d", i), s, r, b);
    end

    // R1: reset mid-run clears outputs
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 main cleared mid-run", 32'({main_sh1, main_sh0}), 32'h0);
    chk("R1 dup cleared mid-run", 32'({dup_sh1, dup_sh0}), 32'h0);
    rst = 1'b0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule